// File: doc/BRIEF.md
# Snooping MSI Line Coherence Controller

This block keeps one cache line coherent among several caches that share a snooping bus. It follows the three-state Modified/Shared/Invalid scheme. The processor side raises read or write requests for the tracked line. A read hit in Shared or Modified, or a write hit in Modified, completes locally. Any other request asks for the bus and issues a shared-read or an exclusive-read transaction. When the grant arrives, the line is installed in the matching state.

The same controller watches bus traffic from the other caches. A snooped exclusive read takes away a Shared copy. When this cache holds the only dirty copy, it answers any snooped read by driving a flush and a memory-cancel strobe in the same cycle. A plain read moves the line to Shared. An exclusive read moves it to Invalid. Data storage, replacement and bus arbitration sit outside this block.

Top module: `msi_line_ctrl`

## Requirements
- R1: A processor read in Invalid raises `bus_req` with `bus_cmd` = 2'b01 (shared read). On the grant cycle the line becomes Shared (`line_state` = 2'b01).
- R2: A processor write in Invalid or Shared raises `bus_req` with `bus_cmd` = 2'b10 (exclusive read). On the grant cycle the line becomes Modified (`line_state` = 2'b10).
- R3: A snooped exclusive read (`snp_cmd` = 2'b10) for the tracked address moves a Shared line to Invalid (2'b00). `flush` and `mem_cancel` stay low.
- R4: A snooped shared read for the tracked address on a Modified line raises `flush` and `mem_cancel` in that same cycle, and the line becomes Shared.
- R5: A snooped exclusive read for the tracked address on a Modified line raises `flush` and `mem_cancel` in that same cycle, and the line becomes Invalid.
- R6: A read in Shared or Modified, or a write in Modified, raises `cpu_ack` one cycle after the request is taken. No bus request is made and the state does not change.
- R7: While a bus request waits for its grant, `bus_req` and `bus_cmd` hold steady and `cpu_ack` stays low. Snoops that arrive in that time still update the line.
- R8: In the cycle in which its own request is granted, the controller ignores the snoop port. That transaction causes no flush.
- R9: `cpu_ack` is high for exactly one cycle per accepted request. For a bus request it rises in the cycle after the grant.
- R10: After reset the line is Invalid, and `cpu_ack`, `bus_req`, `flush` and `mem_cancel` are low.
- R11: A snoop for any other address has no effect. A snooped shared read on a Shared line leaves it Shared without a flush.
- R12: A relevant snoop in the same cycle as a waiting processor request is handled first. The request is then judged against the updated state one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_addr | input | ADDR_W | Address of the tracked line |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_ack | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; the transaction completes in that cycle |
| bus_cmd | output | 2 | 01 shared read, 10 exclusive read |
| bus_addr | output | ADDR_W | Address of the requested line |
| snp_valid | input | 1 | A bus transaction is visible |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| flush | output | 1 | Dirty data driven onto the bus |
| mem_cancel | output | 1 | Memory must not answer this transaction |
| line_state | output | 2 | 00 Invalid, 01 Shared, 10 Modified |

## Verification
The bench builds the controller with an 8-bit address. This keeps a non-matching snoop address a one-constant change, so the address filter sits next to every state check. The bench plays the bus model itself. Grant delays of zero to several cycles reach the waiting state, and snoops injected during that wait exercise R7. The controller's own granted command is mirrored onto the snoop port, and a processor request is made to collide with a snoop on a dirty line.

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic              cpu_req,
  input  logic              cpu_we,
  output logic              cpu_ack,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              flush,
  output logic              mem_cancel,
  output logic [1:0]        line_state
);
  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_M = 2'b10;
  localparam logic [1:0] CMD_RD = 2'b01, CMD_RDX = 2'b10;

  logic [1:0] st_q, cmd_q;
  logic       wait_q, ack_q;
  logic       own_gnt, snp_act, cpu_go, hit, dirty_hit;

  assign own_gnt   = wait_q && bus_gnt;
  assign snp_act   = snp_valid && (snp_addr == line_addr) && !own_gnt &&
                     (snp_cmd == CMD_RD || snp_cmd == CMD_RDX);
  assign dirty_hit = snp_act && (st_q == ST_M);
  assign hit       = cpu_we ? (st_q == ST_M) : (st_q != ST_I);
  assign cpu_go    = cpu_req && !ack_q && !wait_q && !snp_act;

  assign cpu_ack    = ack_q;
  assign bus_req    = wait_q;
  assign bus_cmd    = wait_q ? cmd_q : 2'b00;
  assign bus_addr   = line_addr;
  assign flush      = dirty_hit;
  assign mem_cancel = dirty_hit;
  assign line_state = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_I;
      cmd_q  <= 2'b00;
      wait_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (own_gnt) begin
        st_q   <= (cmd_q == CMD_RDX) ? ST_M : ST_S;
        ack_q  <= 1'b1;
        wait_q <= 1'b0;
      end else if (snp_act) begin
        case (st_q)
          ST_S:    if (snp_cmd == CMD_RDX) st_q <= ST_I;
          ST_M:    st_q <= (snp_cmd == CMD_RD) ? ST_S : ST_I;
          default: st_q <= st_q;
        endcase
      end
      if (cpu_go) begin
        if (hit) begin
          ack_q <= 1'b1;
        end else begin
          wait_q <= 1'b1;
          cmd_q  <= cpu_we ? CMD_RDX : CMD_RD;
        end
      end
    end
  end
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] line_addr,
  input logic              cpu_ack,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              flush,
  input logic [1:0]        line_state
);
  logic snp_mine;
  assign snp_mine = snp_valid && (snp_addr == line_addr) && !(bus_req && bus_gnt);

  p_rd_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == 2'b01 |=> line_state == 2'b01);
  p_rdx_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == 2'b10 |=> line_state == 2'b10);
  p_inval_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snp_mine && snp_cmd == 2'b10 && line_state == 2'b01 |=> line_state == 2'b00);
  p_flush_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> line_state == 2'b10);
  p_flush_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush && snp_cmd == 2'b01 |=> line_state == 2'b01);
  p_flush_rdx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush && snp_cmd == 2'b10 |=> line_state == 2'b00);
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_cmd));
  p_own_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |-> !flush);
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_addr(line_addr), .cpu_ack(cpu_ack),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
  .flush(flush), .line_state(line_state)
);

// File: tb/msi_line_ctrl_tb_top.sv
module msi_line_ctrl_tb_top;
  localparam int AW = 8;
  localparam logic [AW-1:0] LINE = 8'h3C, OTHER = 8'h3D;
  localparam logic [1:0] I = 2'b00, S = 2'b01, M = 2'b10, RD = 2'b01, RDX = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0, bus_gnt = 1'b0, snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'b00;
  logic [AW-1:0] snp_addr = '0;
  logic cpu_ack, bus_req, flush, mem_cancel;
  logic [1:0] bus_cmd, line_state;
  logic [AW-1:0] bus_addr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msi_line_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_addr(LINE), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_ack(cpu_ack), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .flush(flush), .mem_cancel(mem_cancel), .line_state(line_state)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cpu_hit(logic we, string tag);
    cpu_req = 1'b1; cpu_we = we;
    @(negedge clk);
    check({tag, " ack"}, cpu_ack, 1);
    check({tag, " no bus"}, bus_req, 0);
    cpu_req = 1'b0;
    @(negedge clk);
    check("R9 ack single", cpu_ack, 0);
  endtask

  task automatic cpu_miss(logic we, logic [1:0] cmd, int dly, logic [1:0] fin, string tag);
    cpu_req = 1'b1; cpu_we = we;
    @(negedge clk);
    check({tag, " req"}, bus_req, 1);
    check({tag, " cmd"}, bus_cmd, cmd);
    check({tag, " addr"}, bus_addr, LINE);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      check("R7 req held", bus_req, 1);
      check("R7 cmd held", bus_cmd, cmd);
      check("R7 no ack", cpu_ack, 0);
    end
    bus_gnt = 1'b1; snp_valid = 1'b1; snp_cmd = cmd; snp_addr = LINE;
    #1 check("R8 own no flush", flush, 0);
    @(negedge clk);
    bus_gnt = 1'b0; snp_valid = 1'b0; cpu_req = 1'b0;
    check("R9 ack after grant", cpu_ack, 1);
    check({tag, " state"}, line_state, fin);
    check({tag, " req drop"}, bus_req, 0);
    @(negedge clk);
    check("R9 ack single", cpu_ack, 0);
  endtask

  task automatic snoop(logic [1:0] cmd, logic [AW-1:0] a, logic fl, logic [1:0] fin, string tag);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
    #1 check({tag, " flush"}, flush, fl);
    check({tag, " cancel"}, mem_cancel, fl);
    @(negedge clk);
    snp_valid = 1'b0;
    check({tag, " state"}, line_state, fin);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    check("R10 state", line_state, I);
    check("R10 ack", cpu_ack, 0);
    check("R10 req", bus_req, 0);
    check("R10 flush", flush, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_collision;
    cpu_req = 1'b1; cpu_we = 1'b1;
    snp_valid = 1'b1; snp_cmd = RD; snp_addr = LINE;
    #1 check("R12 flush first", flush, 1);
    @(negedge clk);
    snp_valid = 1'b0;
    check("R12 state S", line_state, S);
    check("R12 no ack", cpu_ack, 0);
    @(negedge clk);
    check("R12 rdx req", bus_cmd, RDX);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0; cpu_req = 1'b0;
    check("R12 ack", cpu_ack, 1);
    check("R12 state M", line_state, M);
    @(negedge clk);
  endtask

  task automatic t_wait_snoop;
    cpu_req = 1'b1; cpu_we = 1'b1;
    @(negedge clk);
    check("R7 req", bus_req, 1);
    snoop(RDX, LINE, 0, I, "R7 snoop while waiting");
    check("R7 still req", bus_req, 1);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0; cpu_req = 1'b0;
    check("R7 fill M", line_state, M);
    check("R7 ack", cpu_ack, 1);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    cpu_miss(0, RD, 2, S, "R1 read miss");
    cpu_hit(0, "R6 read hit S");
    snoop(RD, LINE, 0, S, "R11 rd on S");
    snoop(RDX, OTHER, 0, S, "R11 other addr");
    cpu_miss(1, RDX, 0, M, "R2 write from S");
    cpu_hit(0, "R6 read hit M");
    cpu_hit(1, "R6 write hit M");
    snoop(RDX, OTHER, 0, M, "R11 other addr M");
    snoop(RD, LINE, 1, S, "R4 rd on M");
    snoop(RDX, LINE, 0, I, "R3 rdx on S");
    cpu_miss(1, RDX, 3, M, "R2 write from I");
    snoop(RDX, LINE, 1, I, "R5 rdx on M");
    cpu_miss(0, RD, 0, S, "R1 read miss again");
    t_wait_snoop();
    t_collision();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule